// File: doc/BRIEF.md
# Transmit FIFO Empty Interrupt Controller

This block generates the holding-register-empty interrupt request and two transmit status flags for a serial port whose transmit FIFO holds up to 16 characters. It does not store or serialize data. It watches the FIFO occupancy and the shift-register busy flag from the neighbouring blocks. From these it decides when software should be told that the transmit side can accept more characters.

In FIFO mode, the interrupt can be raised at once or after a delay. When the FIFO drains after holding two or more characters at the same time, the interrupt is raised immediately. When the FIFO only ever trickled one character at a time since the last empty status, the interrupt is held back by one character time minus the final stop bit. This stops software from being interrupted once for every single byte. The delay counts bit-rate ticks from the transmitter, up to a frame length that the transmitter also uses. A write to the holding register or a read of the interrupt identification register drops the request. A change of the FIFO-enable bit raises it at once when the FIFO is empty.

Top module: `txe_irq_ctrl`

## Requirements
- R1: After synchronous reset the interrupt output is 0 and both status outputs (`fifo_empty`, `tx_idle`) are 1.
- R2: `fifo_empty` equals 1 exactly when `tx_count` was 0 at the preceding clock edge (one register stage).
- R3: `tx_idle` equals 1 exactly when `tx_count` was 0 and `shift_busy` was 0 at the preceding clock edge; `tx_idle` is never 1 while `fifo_empty` is 0.
- R4: In FIFO mode (`fifo_en`=1), when the occupancy falls to 0 and it has been 2 or more at some clock edge since `fifo_empty` last became 1, the request is raised one cycle after the occupancy reaches 0.
- R5: In FIFO mode, when the occupancy falls to 0 without having reached 2 since `fifo_empty` last became 1, the request is raised after `frame_bits`-1 cycles with `baud_tick` high; with `baud_tick` held at 1 it is visible `frame_bits` cycles after the occupancy reaches 0.
- R6: The delay of R5 advances only on cycles where `baud_tick` is 1; while it is 0 the request stays low indefinitely.
- R7: A `thr_wr` or `iir_rd` pulse clears the pending request on the next edge, and a clear wins over a simultaneous set. A `thr_wr` during the R5 delay cancels that delay, so no request follows.
- R8: With `fifo_en`=0 there is no delay: the request is raised one cycle after the occupancy reaches 0, regardless of the peak occupancy.
- R9: A change of `fifo_en` while the occupancy is 0 raises the request one cycle later.
- R10: `irq` is the pending request gated by `thre_ie`; clearing `thre_ie` hides the request without discarding it, and setting it again shows the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| thre_ie | input | 1 | Transmitter-empty interrupt enable |
| tx_count | input | 5 | Transmit FIFO occupancy (0 to 16) |
| thr_wr | input | 1 | Strobe: write to the holding register |
| iir_rd | input | 1 | Strobe: read of the interrupt identification register reporting this source |
| shift_busy | input | 1 | Transmit shift register is sending |
| baud_tick | input | 1 | One pulse per bit time |
| frame_bits | input | 4 | Bits per character including start, parity and stop bits |
| irq | output | 1 | Transmitter-empty interrupt request |
| fifo_empty | output | 1 | Transmit FIFO empty status |
| tx_idle | output | 1 | FIFO and shift register both empty |

## Verification
The bench builds the block with its default parameters: a 16-deep FIFO, so occupancy is 5 bits wide, and a 4-bit frame-length field. This covers frame lengths from 7 to 12 bits, so the delayed path is timed at several character lengths against the immediate path at peak occupancies from 1 up to the full 16. The 4-bit frame field also keeps every delay short enough to measure cycle by cycle. This makes it possible to hold `baud_tick` low and show that the delay stalls.

// File: rtl/txe_pkg.sv
package txe_pkg;

    localparam int unsigned TXE_DEPTH   = 16;
    localparam int unsigned TXE_FRAME_W = 4;
    localparam int unsigned TXE_MULTI   = 2;

    // Occupancy-derived event bundle handed from the tracker to the control
    typedef struct packed {
        logic now_empty;   // occupancy is zero this cycle
        logic went_empty;  // occupancy just reached zero (status was clear)
        logic was_multi;   // two or more were held since status last set
    } txe_evt_t;

    // Why the pending request is being set this cycle
    typedef enum logic [1:0] {
        SET_NONE  = 2'd0,
        SET_DRAIN = 2'd1,
        SET_TIMER = 2'd2,
        SET_MODE  = 2'd3
    } txe_set_e;

    // Bit times to wait: whole character minus its final stop bit
    function automatic int unsigned char_delay(input int unsigned frame);
        return (frame < 2) ? 1 : frame - 1;
    endfunction

endpackage

// File: rtl/txe_occ_track.sv
module txe_occ_track
    import txe_pkg::*;
#(
    parameter int unsigned CNT_W = 5,
    parameter int unsigned MULTI = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             shift_busy,
    output logic             fifo_empty,
    output logic             tx_idle,
    output txe_evt_t         evt
);
    localparam logic [CNT_W-1:0] MULTI_LVL = CNT_W'(MULTI);

    logic empty_q;
    logic idle_q;
    logic multi_q;
    logic zero_now;

    assign zero_now = (tx_count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b1;
            idle_q  <= 1'b1;
            multi_q <= 1'b0;
        end else begin
            empty_q <= zero_now;
            idle_q  <= zero_now && !shift_busy;
            if (tx_count >= MULTI_LVL) begin
                multi_q <= 1'b1;
            end else if (zero_now && !empty_q) begin
                multi_q <= 1'b0;
            end
        end
    end

    assign fifo_empty     = empty_q;
    assign tx_idle        = idle_q;
    assign evt.now_empty  = zero_now;
    assign evt.went_empty = zero_now && !empty_q;
    assign evt.was_multi  = multi_q;

    AST_IDLE_IMPLIES_EMPTY: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> fifo_empty); // R3

    AST_MULTI_CLEARED_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(empty_q) |-> !multi_q); // R4

endmodule

// File: rtl/txe_char_timer.sv
module txe_char_timer
    import txe_pkg::*;
#(
    parameter int unsigned FRAME_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               cancel,
    input  logic               tick,
    input  logic [FRAME_W-1:0] frame_bits,
    output logic               busy,
    output logic               expire
);
    localparam logic [FRAME_W-1:0] ONE = FRAME_W'(1);

    logic [FRAME_W-1:0] cnt_q;
    logic               busy_q;

    assign expire = busy_q && tick && !cancel && (cnt_q == ONE);
    assign busy   = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (cancel) begin
            busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= FRAME_W'(char_delay(int'(frame_bits)));
        end else if (busy_q && tick) begin
            if (cnt_q == ONE) begin
                busy_q <= 1'b0;
            end
            cnt_q <= cnt_q - ONE;
        end
    end

    AST_TIMER_NONZERO: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q != '0)); // R5

    AST_TIMER_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tick && !cancel && !start) |=> (busy_q && $stable(cnt_q))); // R6

endmodule

// File: rtl/txe_pend.sv
module txe_pend
    import txe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  txe_set_e set_src,
    input  logic     clr,
    output logic     pending
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (clr) begin
            pend_q <= 1'b0;
        end else if (set_src != SET_NONE) begin
            pend_q <= 1'b1;
        end
    end

    assign pending = pend_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pending); // R7

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (set_src != SET_NONE && !clr) |=> pending); // R4

endmodule

// File: rtl/txe_irq_ctrl.sv
module txe_irq_ctrl
    import txe_pkg::*;
#(
    parameter int unsigned DEPTH   = TXE_DEPTH,
    parameter int unsigned FRAME_W = TXE_FRAME_W,
    parameter int unsigned MULTI   = TXE_MULTI,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fifo_en,
    input  logic               thre_ie,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic               thr_wr,
    input  logic               iir_rd,
    input  logic               shift_busy,
    input  logic               baud_tick,
    input  logic [FRAME_W-1:0] frame_bits,
    output logic               irq,
    output logic               fifo_empty,
    output logic               tx_idle
);
    txe_evt_t evt;
    txe_set_e set_src;
    logic     fen_q;
    logic     mode_chg;
    logic     need_delay;
    logic     tmr_start;
    logic     tmr_cancel;
    logic     tmr_busy;
    logic     tmr_expire;
    logic     pending;

    txe_occ_track #(
        .CNT_W (CNT_W),
        .MULTI (MULTI)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .tx_count   (tx_count),
        .shift_busy (shift_busy),
        .fifo_empty (fifo_empty),
        .tx_idle    (tx_idle),
        .evt        (evt)
    );

    always_ff @(posedge clk) begin
        fen_q <= fifo_en;
    end

    assign mode_chg   = !rst && (fifo_en != fen_q);
    assign need_delay = fifo_en && !evt.was_multi;
    assign tmr_start  = evt.went_empty && need_delay;
    assign tmr_cancel = thr_wr || !evt.now_empty || mode_chg;

    txe_char_timer #(
        .FRAME_W (FRAME_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start      (tmr_start),
        .cancel     (tmr_cancel),
        .tick       (baud_tick),
        .frame_bits (frame_bits),
        .busy       (tmr_busy),
        .expire     (tmr_expire)
    );

    always_comb begin
        set_src = SET_NONE;
        if (mode_chg && evt.now_empty) begin
            set_src = SET_MODE;
        end else if (evt.went_empty && !need_delay) begin
            set_src = SET_DRAIN;
        end else if (tmr_expire) begin
            set_src = SET_TIMER;
        end
    end

    txe_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_src (set_src),
        .clr     (thr_wr || iir_rd),
        .pending (pending)
    );

    assign irq = pending && thre_ie;

    AST_DELAY_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        tmr_busy |-> fifo_empty); // R5

    AST_NO_DELAY_OUTSIDE_FIFO: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !$past(fifo_en)) |-> !tmr_busy); // R8

    AST_MODE_CHANGE_RAISES: assert property (@(posedge clk) disable iff (rst)
        (mode_chg && evt.now_empty && !thr_wr && !iir_rd) |=> pending); // R9

endmodule

// File: tb/txe_irq_ctrl_tb.sv
module txe_irq_ctrl_tb;
    localparam int unsigned CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst;
    logic             fifo_en, thre_ie, thr_wr, iir_rd, shift_busy, baud_tick;
    logic [CNT_W-1:0] tx_count;
    logic [3:0]       frame_bits;
    logic             irq, fifo_empty, tx_idle;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    txe_irq_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .fifo_en    (fifo_en),
        .thre_ie    (thre_ie),
        .tx_count   (tx_count),
        .thr_wr     (thr_wr),
        .iir_rd     (iir_rd),
        .shift_busy (shift_busy),
        .baud_tick  (baud_tick),
        .frame_bits (frame_bits),
        .irq        (irq),
        .fifo_empty (fifo_empty),
        .tx_idle    (tx_idle)
    );

    // {fifo_en, frame_bits[3:0], peak[4:0], expected latency[7:0]}
    localparam int NVEC = 7;
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 4'd10, 5'd1,  8'd10},
        {1'b1, 4'd10, 5'd2,  8'd1},
        {1'b1, 4'd7,  5'd1,  8'd7},
        {1'b1, 4'd12, 5'd1,  8'd12},
        {1'b1, 4'd11, 5'd16, 8'd1},
        {1'b1, 4'd8,  5'd3,  8'd1},
        {1'b0, 4'd10, 5'd1,  8'd1}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input logic [CNT_W-1:0] n);
        tx_count = n;
        thr_wr   = 1'b1;
        step();
        thr_wr   = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fifo_en = 1'b1; thre_ie = 1'b1; thr_wr = 1'b0; iir_rd = 1'b0;
        shift_busy = 1'b0; baud_tick = 1'b1; tx_count = '0; frame_bits = 4'd10;
        step(); step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        chk(fifo_empty == 1'b1, "R1 fifo_empty", int'(fifo_empty), 1);
        chk(tx_idle == 1'b1, "R1 tx_idle", int'(tx_idle), 1);

        // R3 shift register busy keeps tx_idle low
        shift_busy = 1'b1;
        step();
        chk(tx_idle == 1'b0, "R3 idle while shifting", int'(tx_idle), 0);
        chk(fifo_empty == 1'b1, "R3 empty while shifting", int'(fifo_empty), 1);
        shift_busy = 1'b0;
        step();
        chk(tx_idle == 1'b1, "R3 idle after shift", int'(tx_idle), 1);

        // Table walk: R2 R4 R5 R8
        for (int v = 0; v < NVEC; v++) begin
            int lat;
            fifo_en    = VEC[v][17];
            frame_bits = VEC[v][16:13];
            step();
            iir_rd = 1'b1; step(); iir_rd = 1'b0;
            load(VEC[v][12:8]);
            step(); step();
            chk(fifo_empty == 1'b0, "R2 not empty when loaded", int'(fifo_empty), 0);
            tx_count = '0;
            lat = 0;
            for (int n = 1; n <= 60; n++) begin
                step();
                if (n == 1) chk(fifo_empty == 1'b1, "R2 empty one cycle after drain", int'(fifo_empty), 1);
                if (irq) begin
                    lat = n;
                    break;
                end
            end
            chk(lat == int'(VEC[v][7:0]),
                VEC[v][17] ? (VEC[v][12:8] >= 2 ? "R4 immediate latency" : "R5 delayed latency")
                           : "R8 non-FIFO latency",
                lat, int'(VEC[v][7:0]));
        end

        // R7 clear by identification read
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk(irq == 1'b0, "R7 cleared by iir_rd", int'(irq), 0);

        // R9 mode change with empty FIFO (currently fifo_en = 0)
        fifo_en = 1'b1;
        step();
        chk(irq == 1'b1, "R9 raise on mode change", int'(irq), 1);

        // R7 clear by holding-register write
        thr_wr = 1'b1; step(); thr_wr = 1'b0;
        chk(irq == 1'b0, "R7 cleared by thr_wr", int'(irq), 0);

        // R7 write during delay cancels it
        frame_bits = 4'd10;
        load(5'd1);
        tx_count = '0;
        step(); step(); step();
        thr_wr = 1'b1; step(); thr_wr = 1'b0;
        begin
            logic seen = 1'b0;
            for (int n = 0; n < 20; n++) begin
                step();
                if (irq) seen = 1'b1;
            end
            chk(seen == 1'b0, "R7 delay cancelled by write", int'(seen), 0);
        end

        // R6 delay stalls without bit ticks
        baud_tick = 1'b0;
        load(5'd1);
        tx_count = '0;
        begin
            logic seen = 1'b0;
            for (int n = 0; n < 30; n++) begin
                step();
                if (irq) seen = 1'b1;
            end
            chk(seen == 1'b0, "R6 no irq without ticks", int'(seen), 0);
        end
        baud_tick = 1'b1;
        for (int n = 0; n < 8; n++) step();
        chk(irq == 1'b0, "R6 eight ticks not enough", int'(irq), 0);
        step();
        chk(irq == 1'b1, "R6 ninth tick raises", int'(irq), 1);

        // R10 enable masks without discarding
        thre_ie = 1'b0;
        step();
        chk(irq == 1'b0, "R10 masked", int'(irq), 0);
        thre_ie = 1'b1;
        step();
        chk(irq == 1'b1, "R10 pending retained", int'(irq), 1);

        // R1 reset mid-operation
        tx_count = 5'd4;
        rst = 1'b1; step(); rst = 1'b0; tx_count = '0;
        chk(irq == 1'b0 && fifo_empty == 1'b1 && tx_idle == 1'b1, "R1 reset clears",
            int'({irq, fifo_empty, tx_idle}), 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule